// File: doc/BRIEF.md
# Keypad Combination Lock Controller

This block is the decision core of a keyless door lock. It receives key events that have already been scanned and debounced. Each event is a single-cycle strobe carrying the key's matrix position. The block compares every key, as it arrives, with the stored digit for the current position. When a four-digit entry completes, the block drives two toggling lock outputs, an inverted lock-status lamp output, a momentary strike pulse, a tamper pulse and a latched alarm.

Three codes are held: primary, secondary and duress. All three share their first three digits, so only the fourth digit decides which action runs. A single six-digit programming sequence rewrites all three codes. Program mode is entered only after a valid secondary code has been accepted, followed by two presses of the arming key.

Key events use a valid/ready pair. `key_ready` is held high at all times, so the block never applies back-pressure. A key is consumed on every clock edge where `key_valid` is high, and strobes may arrive on back-to-back cycles. All durations are parameters counted in clock cycles.

Top module: `keylock_ctrl`

## Requirements
- R1: After reset, `lock1_o`, `lock2_o`, `alarm_o`, `moment_o`, `tamper_o` and `prog_o` are low, and `lock_status_o` is high. A key code is {column-1, row-1}: bits [3:2] hold the column and bits [1:0] hold the row. The default primary code is 0,1,5,4, the default secondary code is 0,1,5,0 and the default duress code is 0,1,5,1.
- R2: A completed primary code toggles `lock1_o`, clears `alarm_o`, and raises `moment_o` for exactly MOM_CYC cycles starting at the edge that takes the fourth key.
- R3: A completed secondary code toggles `lock2_o`. When the secondary and primary codes are equal, one entry toggles both `lock1_o` and `lock2_o`.
- R4: A completed duress code toggles `lock1_o` and sets `alarm_o`. `alarm_o` stays high through other entries until a primary code is completed. If the duress and primary codes are ever equal, the primary action takes priority.
- R5: Outside program mode, a key that matches no stored code at the current position raises `tamper_o` for exactly TMP_CYC cycles. The digit position is reset, so a following correct four-digit code is accepted.
- R6: Every key of an entry must arrive fewer than TIMEOUT_CYC cycles after the entry's first key. If the timeout is reached, the entry is dropped without a tamper pulse, and the next key counts as a first digit.
- R7: `lock_status_o` always equals the inverse of `lock1_o`.
- R8: After a secondary code is accepted, two presses of key 4'hC (column 4, row 1) that fall within the same timeout window raise `prog_o` at the second press. While `prog_o` is high the entry timeout does not run.
- R9: In program mode, six keys are collected. On the sixth key, `prog_o` falls and the new codes take effect: digits 1-4 form the primary code, digits 1-3 plus digit 5 form the secondary code, and digits 1-3 plus digit 6 form the duress code. No tamper pulse is produced in program mode.
- R10: In program mode, key 4'hE (column 4, row 3) restarts the six-digit collection and is not stored as a digit.
- R11: A new trigger during an active momentary or tamper pulse restarts that pulse at its full width.
- R12: `key_ready` is always high, and keys presented on consecutive cycles are each consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| key_valid | input | 1 | Key strobe |
| key_ready | output | 1 | Always high, no back-pressure |
| key_code | input | 4 | Key position {column-1, row-1} |
| lock1_o | output | 1 | Toggled by primary and duress codes |
| lock2_o | output | 1 | Toggled by secondary code |
| lock_status_o | output | 1 | Inverse of lock1_o |
| moment_o | output | 1 | Momentary pulse on primary code |
| tamper_o | output | 1 | Pulse on a rejected key |
| alarm_o | output | 1 | Latched on duress code |
| prog_o | output | 1 | Program mode flag |

## Verification
Every output that a key affects (the lock, alarm and program-mode outputs, and the rising edge of either pulse) changes on the same clock edge that samples the key. The bench therefore drives each key on a falling edge and reads the results on the next falling edge. Pulse widths are measured by counting high samples on falling edges from that point on, so a momentary or tamper pulse must read exactly its parameter value. Timeout cases wait well past TIMEOUT_CYC before the next key, so the result never depends on a single boundary cycle.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  localparam int KEY_W       = 4;
  localparam int CODE_LEN    = 4;
  localparam int PREFIX_LEN  = CODE_LEN - 1;
  localparam int PROG_DIGITS = 6;
  localparam int PTR_W       = $clog2(CODE_LEN);
  localparam int PC_W        = $clog2(PROG_DIGITS);

  typedef logic [KEY_W-1:0] key_t;
  typedef enum logic [1:0] {ARM_IDLE, ARM_WAIT1, ARM_WAIT2} arm_e;

  localparam key_t ARM_KEY     = 4'hC;
  localparam key_t RESTART_KEY = 4'hE;

  // index 0 is the first digit entered
  localparam key_t [PREFIX_LEN-1:0] DEF_PREFIX = {4'h5, 4'h1, 4'h0};
  localparam key_t DEF_PRI_LAST = 4'h4;
  localparam key_t DEF_SEC_LAST = 4'h0;
  localparam key_t DEF_DUR_LAST = 4'h1;
endpackage

// File: rtl/keylock_pulse.sv
module keylock_pulse #(
  parameter int unsigned WIDTH = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(WIDTH + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (trig_i)           cnt_q <= CW'(WIDTH);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end

  assign pulse_o = (cnt_q != '0);

  // a trigger must keep the pulse alive on the following cycle (R11)
  p_retrig_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> !$past(trig_i));
endmodule

// File: rtl/keylock_entry_timer.sv
module keylock_entry_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire_o = run_q && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (stop_i || expire_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // expiry ends the window; a new one needs a fresh start (R6)
  p_expire_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
endmodule

// File: rtl/keylock_code_store.sv
module keylock_code_store
  import keylock_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit_i,
  input  key_t [PREFIX_LEN-1:0]   new_pre_i,
  input  key_t                    new_pri_i,
  input  key_t                    new_sec_i,
  input  key_t                    new_dur_i,
  input  logic [PTR_W-1:0]        idx_i,
  input  key_t                    key_i,
  output logic                    pre_hit_o,
  output logic                    hit_pri_o,
  output logic                    hit_sec_o,
  output logic                    hit_dur_o
);
  key_t [PREFIX_LEN-1:0] pre_q;
  key_t                  pri_q, sec_q, dur_q;
  logic [CODE_LEN-1:0]   dig_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= DEF_PREFIX;
      pri_q <= DEF_PRI_LAST;
      sec_q <= DEF_SEC_LAST;
      dur_q <= DEF_DUR_LAST;
    end else if (commit_i) begin
      pre_q <= new_pre_i;
      pri_q <= new_pri_i;
      sec_q <= new_sec_i;
      dur_q <= new_dur_i;
    end
  end

  for (genvar g = 0; g < CODE_LEN; g++) begin : g_cmp
    if (g < PREFIX_LEN) begin : g_pre
      assign dig_eq[g] = (pre_q[g] == key_i);
    end else begin : g_tail
      assign dig_eq[g] = 1'b0;
    end
  end

  assign pre_hit_o = dig_eq[idx_i];
  assign hit_pri_o = (pri_q == key_i);
  assign hit_sec_o = (sec_q == key_i);
  assign hit_dur_o = (dur_q == key_i);
endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
  import keylock_pkg::*;
#(
  parameter int unsigned MOM_CYC     = 50,
  parameter int unsigned TMP_CYC     = 50,
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  output logic       key_ready,
  input  logic [3:0] key_code,
  output logic       lock1_o,
  output logic       lock2_o,
  output logic       lock_status_o,
  output logic       moment_o,
  output logic       tamper_o,
  output logic       alarm_o,
  output logic       prog_o
);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(CODE_LEN - 1);
  localparam logic [PC_W-1:0]  LAST_PROG = PC_W'(PROG_DIGITS - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d, eff_ptr;
  arm_e             arm_q, arm_d, eff_arm;
  logic             prog_q, prog_d;
  logic [PC_W-1:0]  pcnt_q, pcnt_d;
  key_t [PROG_DIGITS-2:0] stg_q, stg_d;
  logic lock1_q, lock1_d, lock2_q, lock2_d, alarm_q, alarm_d;
  logic mom_fire, tmp_fire, tmr_start, tmr_stop, tmr_exp, commit;
  logic pre_hit, hit_p, hit_s, hit_u;

  assign eff_ptr = tmr_exp ? '0 : ptr_q;
  assign eff_arm = tmr_exp ? ARM_IDLE : arm_q;

  keylock_code_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .new_pre_i (stg_q[PREFIX_LEN-1:0]),
    .new_pri_i (stg_q[PREFIX_LEN]),
    .new_sec_i (stg_q[PREFIX_LEN+1]),
    .new_dur_i (key_code),
    .idx_i     (eff_ptr),
    .key_i     (key_code),
    .pre_hit_o (pre_hit),
    .hit_pri_o (hit_p),
    .hit_sec_o (hit_s),
    .hit_dur_o (hit_u)
  );

  keylock_entry_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (tmr_start),
    .stop_i   (tmr_stop),
    .expire_o (tmr_exp)
  );

  keylock_pulse #(.WIDTH(MOM_CYC)) u_mom (
    .clk (clk), .rst_n (rst_n), .trig_i (mom_fire), .pulse_o (moment_o)
  );

  keylock_pulse #(.WIDTH(TMP_CYC)) u_tmp (
    .clk (clk), .rst_n (rst_n), .trig_i (tmp_fire), .pulse_o (tamper_o)
  );

  always_comb begin
    ptr_d = ptr_q;  arm_d = arm_q;  prog_d = prog_q;  pcnt_d = pcnt_q;
    stg_d = stg_q;  lock1_d = lock1_q;  lock2_d = lock2_q;  alarm_d = alarm_q;
    mom_fire = 1'b0;  tmp_fire = 1'b0;  tmr_start = 1'b0;  tmr_stop = 1'b0;
    commit = 1'b0;
    if (key_valid && prog_q) begin
      if (key_code == RESTART_KEY) begin
        pcnt_d = '0;
      end else if (pcnt_q == LAST_PROG) begin
        commit = 1'b1;
        prog_d = 1'b0;
        pcnt_d = '0;
      end else begin
        stg_d[pcnt_q] = key_code;
        pcnt_d = pcnt_q + PC_W'(1);
      end
    end else if (key_valid) begin
      if (eff_arm == ARM_WAIT1 && key_code == ARM_KEY) begin
        arm_d = ARM_WAIT2;
      end else if (eff_arm == ARM_WAIT2 && key_code == ARM_KEY) begin
        prog_d   = 1'b1;
        arm_d    = ARM_IDLE;
        pcnt_d   = '0;
        ptr_d    = '0;
        tmr_stop = 1'b1;
      end else begin
        arm_d = ARM_IDLE;
        if (eff_ptr != LAST_PTR) begin
          if (pre_hit) begin
            ptr_d = eff_ptr + PTR_W'(1);
            if (eff_ptr == '0) tmr_start = 1'b1;
          end else begin
            tmp_fire = 1'b1;
            ptr_d    = '0;
            tmr_stop = 1'b1;
          end
        end else if (hit_p || hit_s || hit_u) begin
          ptr_d = '0;
          if (hit_p || hit_u) lock1_d = ~lock1_q;
          if (hit_s) begin
            lock2_d = ~lock2_q;
            arm_d   = ARM_WAIT1;
          end else begin
            tmr_stop = 1'b1;
          end
          if (hit_p) begin
            alarm_d  = 1'b0;
            mom_fire = 1'b1;
          end else if (hit_u) begin
            alarm_d = 1'b1;
          end
        end else begin
          tmp_fire = 1'b1;
          ptr_d    = '0;
          tmr_stop = 1'b1;
        end
      end
    end else if (tmr_exp) begin
      ptr_d = '0;
      arm_d = ARM_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      arm_q   <= ARM_IDLE;
      prog_q  <= 1'b0;
      pcnt_q  <= '0;
      stg_q   <= '0;
      lock1_q <= 1'b0;
      lock2_q <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      arm_q   <= arm_d;
      prog_q  <= prog_d;
      pcnt_q  <= pcnt_d;
      stg_q   <= stg_d;
      lock1_q <= lock1_d;
      lock2_q <= lock2_d;
      alarm_q <= alarm_d;
    end
  end

  assign key_ready     = 1'b1;
  assign lock1_o       = lock1_q;
  assign lock2_o       = lock2_q;
  assign lock_status_o = ~lock1_q;
  assign alarm_o       = alarm_q;
  assign prog_o        = prog_q;

  // lock1 moves only on a consumed key (R2)
  p_lock1_on_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock1_q != $past(lock1_q)) |-> $past(key_valid));

  // alarm is raised only by a normal-mode key (R4)
  p_alarm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> $past(key_valid && !prog_q));

  // no tamper pulse may start from program mode (R9)
  p_no_tamper_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tamper_o) |-> $past(!prog_q));

  // the entry timer never expires while programming (R8)
  p_timer_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q |-> !tmr_exp);

  // leaving program mode needs a key (R9)
  p_prog_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_q) |-> $past(key_valid));
endmodule

// File: tb/keylock_ctrl_tb.sv
module keylock_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MOM = 5;
  localparam int TMP = 3;
  localparam int TO  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_valid = 1'b0;
  logic [3:0] key_code = 4'h0;
  logic key_ready, lock1, lock2, lstat, mom, tmp, alarm, prog;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic exp_l1 = 1'b0, exp_l2 = 1'b0, exp_al = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keylock_ctrl #(.MOM_CYC(MOM), .TMP_CYC(TMP), .TIMEOUT_CYC(TO)) dut_i (
    .clk (clk), .rst_n (rst_n), .key_valid (key_valid), .key_ready (key_ready),
    .key_code (key_code), .lock1_o (lock1), .lock2_o (lock2),
    .lock_status_o (lstat), .moment_o (mom), .tamper_o (tmp),
    .alarm_o (alarm), .prog_o (prog)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press(input logic [3:0] k);
    @(negedge clk);
    key_valid = 1'b1;
    key_code  = k;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic enter4(input logic [3:0] a, b, c, d);
    press(a); press(b); press(c); press(d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic width_of(input bit pick_tmp, output int n);
    n = 0;
    while ((pick_tmp ? tmp : mom) && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic locks(input string req);
    chk({req, " lock1"}, int'(lock1), int'(exp_l1));
    chk({req, " lock2"}, int'(lock2), int'(exp_l2));
    chk({req, " alarm"}, int'(alarm), int'(exp_al));
    chk("R7 status", int'(lstat), int'(!exp_l1));
  endtask

  task automatic t_reset();
    chk("R1 lock1", int'(lock1), 0);
    chk("R1 lock2", int'(lock2), 0);
    chk("R1 alarm", int'(alarm), 0);
    chk("R1 mom",   int'(mom), 0);
    chk("R1 tamper", int'(tmp), 0);
    chk("R1 prog",  int'(prog), 0);
    chk("R1 status", int'(lstat), 1);
    chk("R12 ready", int'(key_ready), 1);
  endtask

  task automatic t_primary();
    int n;
    enter4(4'h0, 4'h1, 4'h5, 4'h4);
    exp_l1 = ~exp_l1;
    locks("R2 primary");
    width_of(1'b0, n);
    chk("R2 mom width", n, MOM);
  endtask

  task automatic t_secondary();
    enter4(4'h0, 4'h1, 4'h5, 4'h0);
    exp_l2 = ~exp_l2;
    locks("R3 secondary");
    chk("R3 no mom", int'(mom), 0);
  endtask

  task automatic t_duress();
    enter4(4'h0, 4'h1, 4'h5, 4'h1);
    exp_l1 = ~exp_l1; exp_al = 1'b1;
    locks("R4 duress");
    enter4(4'h0, 4'h1, 4'h5, 4'h0);
    exp_l2 = ~exp_l2;
    locks("R4 alarm held");
    enter4(4'h0, 4'h1, 4'h5, 4'h4);
    exp_l1 = ~exp_l1; exp_al = 1'b0;
    locks("R4 alarm cleared");
    idle(MOM + 2);
  endtask

  task automatic t_tamper();
    int n;
    press(4'h0);
    press(4'hF);
    chk("R5 tamper", int'(tmp), 1);
    width_of(1'b1, n);
    chk("R5 tamper width", n, TMP);
    enter4(4'h0, 4'h1, 4'h5, 4'h4);
    exp_l1 = ~exp_l1;
    locks("R5 pointer reset");
    chk("R5 no tamper", int'(tmp), 0);
    idle(MOM + 2);
  endtask

  task automatic t_retrigger();
    int n;
    press(4'hF);
    press(4'hF);
    width_of(1'b1, n);
    chk("R11 tamper restarted", n, TMP);
    enter4(4'h0, 4'h1, 4'h5, 4'h4);
    exp_l1 = ~exp_l1;
    press(4'h0);
    idle(2);
    press(4'h0); // restart nothing: primary first digit again after pointer reset? no, mismatch at pos 2
    // second key 0 is wrong at position 2, so a tamper fired; wait it out
    idle(TMP + 1);
    enter4(4'h0, 4'h1, 4'h5, 4'h4);
    exp_l1 = ~exp_l1;
    locks("R11 after retrigger");
    // momentary restart: two primaries spaced closely
    enter4(4'h0, 4'h1, 4'h5, 4'h4);
    exp_l1 = ~exp_l1;
    width_of(1'b0, n);
    chk("R11 mom width", n, MOM);
    idle(2);
  endtask

  task automatic t_timeout();
    press(4'h0); press(4'h1);
    idle(TO + 10);
    chk("R6 no tamper on expiry", int'(tmp), 0);
    enter4(4'h0, 4'h1, 4'h5, 4'h4);
    exp_l1 = ~exp_l1;
    locks("R6 fresh entry");
    idle(MOM + 2);
    press(4'h0); press(4'h1); press(4'h5);
    idle(TO + 10);
    press(4'h4);
    chk("R6 late key is first digit", int'(tmp), 1);
    locks("R6 late key no action");
    idle(TMP + 2);
  endtask

  task automatic t_back_to_back();
    chk("R12 ready", int'(key_ready), 1);
    @(negedge clk); key_valid = 1'b1; key_code = 4'h0;
    @(negedge clk); key_code = 4'h1;
    @(negedge clk); key_code = 4'h5;
    @(negedge clk); key_code = 4'h4;
    @(negedge clk); key_valid = 1'b0;
    exp_l1 = ~exp_l1;
    locks("R12 consecutive");
    chk("R12 mom", int'(mom), 1);
    idle(MOM + 2);
  endtask

  task automatic t_program();
    enter4(4'h0, 4'h1, 4'h5, 4'h0);
    exp_l2 = ~exp_l2;
    press(4'hC);
    chk("R8 one arm key", int'(prog), 0);
    press(4'hC);
    chk("R8 prog entered", int'(prog), 1);
    press(4'h3); press(4'h2); press(4'h6);
    idle(TO + 10);
    chk("R8 timer frozen", int'(prog), 1);
    press(4'h7); press(4'h8);
    chk("R9 no tamper", int'(tmp), 0);
    chk("R9 prog held", int'(prog), 1);
    press(4'h9);
    chk("R9 prog done", int'(prog), 0);
    press(4'h0);
    chk("R9 old code rejected", int'(tmp), 1);
    idle(TMP + 2);
    enter4(4'h3, 4'h2, 4'h6, 4'h7);
    exp_l1 = ~exp_l1;
    locks("R9 new primary");
    enter4(4'h3, 4'h2, 4'h6, 4'h9);
    exp_l1 = ~exp_l1; exp_al = 1'b1;
    locks("R9 new duress");
    enter4(4'h3, 4'h2, 4'h6, 4'h7);
    exp_l1 = ~exp_l1; exp_al = 1'b0;
    locks("R9 primary clears");
    idle(MOM + 2);
  endtask

  task automatic t_restart();
    int n;
    enter4(4'h3, 4'h2, 4'h6, 4'h8);
    exp_l2 = ~exp_l2;
    locks("R9 new secondary");
    press(4'hC); press(4'hC);
    chk("R8 re-armed", int'(prog), 1);
    press(4'h1); press(4'h1); press(4'hE);
    chk("R10 prog after restart", int'(prog), 1);
    press(4'h0); press(4'h1); press(4'h5); press(4'h4); press(4'h4);
    chk("R10 restart not stored", int'(prog), 1);
    press(4'h1);
    chk("R10 prog done", int'(prog), 0);
    enter4(4'h0, 4'h1, 4'h5, 4'h4);
    exp_l1 = ~exp_l1; exp_l2 = ~exp_l2;
    locks("R3 identical codes");
    width_of(1'b0, n);
    chk("R3 mom width", n, MOM);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_primary();
    t_secondary();
    t_duress();
    t_tamper();
    t_retrigger();
    t_timeout();
    t_back_to_back();
    t_program();
    t_restart();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule